// File: doc/BRIEF.md
# Z-ordered layer compositor

The block merges up to four RGB layers into a single output pixel stream. A scan position (x, y) enters every cycle together with one colour and one per-pixel alpha for each layer at that position. For each layer the block holds a rectangle inside the output area, a stacking rank, a global opacity factor, a flag that selects premultiplied or straight per-pixel alpha, and an optional transparency key colour. A programmable background colour is the bottom of every stack, so it shows wherever nothing is drawn.

Stacking is resolved from the configuration alone. Layers are folded onto the background from the lowest rank to the highest. Between equal ranks the higher layer index is folded last, so it lands on top. The blend path has a fixed depth of four clock cycles. The scan position and a valid marker travel down the pipeline with the pixel, so downstream logic receives the finished colour already tagged with its coordinate.

Pixels are packed with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. In the per-layer vectors, layer i occupies slice i.

Top module: `alpha_compositor`

## Requirements
- R1: A pixel presented with `in_valid` high appears on `out_valid`, `out_x`, `out_y` and `out_pix` exactly four rising edges later, with its own coordinate. Cycles with `in_valid` low produce no output.
- R2: A layer covers the position (x, y) only when x0 <= x < x0 + w and y0 <= y < y0 + h. A layer with zero width or height covers nothing. Outside its rectangle a layer has no effect on the result.
- R3: The effective alpha of a layer is round(pixel_alpha * global_alpha / 255). For a layer in straight mode, one fold step computes round((src * a + dst * (255 - a)) / 255) per channel.
- R4: For a layer in premultiplied mode, one fold step computes min(255, round(src * global_alpha / 255) + round(dst * (255 - a) / 255)) per channel. Here a is the effective alpha.
- R5: Layers are folded onto the background in ascending order of their 2-bit rank. An opaque layer with a higher rank hides every layer with a lower rank.
- R6: Among layers of equal rank, the layer with the higher index is folded later and ends up on top.
- R7: When a layer's key enable is set and its 24-bit pixel equals its key colour exactly, that pixel is transparent. When the key enable is clear, a matching pixel is drawn normally.
- R8: Where no layer is drawn, the output is the background colour `cfg_bg`.
- R9: While reset is held, and directly after it, `out_valid` is low and `out_pix` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A scan position is presented this cycle |
| in_x | input | 12 | Horizontal scan position |
| in_y | input | 12 | Vertical scan position |
| in_pix | input | 4x24 | Per-layer colour at the scan position |
| in_alpha | input | 4x8 | Per-layer per-pixel alpha |
| cfg_x0 | input | 4x12 | Rectangle left edge per layer |
| cfg_y0 | input | 4x12 | Rectangle top edge per layer |
| cfg_w | input | 4x12 | Rectangle width per layer |
| cfg_h | input | 4x12 | Rectangle height per layer |
| cfg_z | input | 4x2 | Stacking rank per layer |
| cfg_galpha | input | 4x8 | Global opacity per layer |
| cfg_premul | input | 4 | Per layer: 1 = premultiplied alpha, 0 = straight alpha |
| cfg_key_en | input | 4 | Per layer: transparency key enable |
| cfg_key | input | 4x24 | Per-layer transparency key colour |
| cfg_bg | input | 24 | Background colour |
| out_valid | output | 1 | Output pixel is valid |
| out_x | output | 12 | Horizontal position of the output pixel |
| out_y | output | 12 | Vertical position of the output pixel |
| out_pix | output | 24 | Composited colour |

## Verification
Directed patterns come first. Probes on each side of every rectangle edge show whether a bound is inclusive or exclusive. A half-transparent layer over a known background separates the straight formula from the premultiplied one, and a white-on-white premultiplied case shows whether the sum saturates. Swapping the ranks of two opaque layers, and then giving them equal ranks, shows whether ordering follows the rank or the index. Matching and non-matching pixels, with the key enabled and then disabled, show that keying depends on an exact match and on its enable bit. Seeded random configurations then mix ranks, modes, keys and overlapping rectangles, and each pixel is compared against a bench model that walks the ranks in order.

// File: rtl/comp_pkg.sv
package comp_pkg;

    localparam int CW    = 8;
    localparam int PIX_W = 3 * CW;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    // One layer's contribution, already reduced to what a fold step needs
    typedef struct packed {
        rgb_t          src;     // straight: raw colour, premultiplied: scaled colour
        logic [CW-1:0] alpha;   // effective alpha
        logic          premul;
        logic          hit;     // layer is drawn at this position
    } term_t;

    // Exact round(p / 255) for p in 0..65025
    function automatic logic [CW-1:0] div255(input logic [15:0] p);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, p} + 17'd128;
        u = t + (t >> 8);
        return u[15:8];
    endfunction

    function automatic logic [CW-1:0] mul_norm(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return div255(16'(a) * 16'(b));
    endfunction

    function automatic logic [CW-1:0] fold_chan(input logic [CW-1:0] s,
                                                input logic [CW-1:0] a,
                                                input logic [CW-1:0] d,
                                                input logic          pm);
        logic [CW-1:0] ia;
        logic [15:0]   dp;
        logic [CW:0]   sum;
        ia = 8'd255 - a;
        dp = 16'(d) * 16'(ia);
        if (pm) begin
            sum = {1'b0, s} + {1'b0, div255(dp)};
            return sum[CW] ? 8'hFF : sum[CW-1:0];
        end
        return div255(16'(s) * 16'(a) + dp);
    endfunction

    function automatic rgb_t fold_px(input rgb_t dst, input term_t t);
        rgb_t o;
        if (!t.hit) return dst;
        o.r = fold_chan(t.src.r, t.alpha, dst.r, t.premul);
        o.g = fold_chan(t.src.g, t.alpha, dst.g, t.premul);
        o.b = fold_chan(t.src.b, t.alpha, dst.b, t.premul);
        return o;
    endfunction

endpackage

// File: rtl/comp_zsort.sv
module comp_zsort #(
    parameter int NL = 4,
    parameter int ZW = 2,
    parameter int IW = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NL-1:0][ZW-1:0]  z,
    output logic [NL-1:0][IW-1:0]  order
);

    logic [NL-1:0][IW-1:0] rank;
    logic [NL-1:0][NL-1:0] match;

    // rank of a layer = number of layers that must be folded before it
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            logic [IW:0] cnt;
            cnt = '0;
            for (int j = 0; j < NL; j++) begin
                if ((z[j] < z[i]) || ((z[j] == z[i]) && (j < i)))
                    cnt = cnt + 1'b1;
            end
            rank[i] = cnt[IW-1:0];
        end
    end

    always_comb begin
        for (int r = 0; r < NL; r++) begin
            order[r] = '0;
            for (int i = 0; i < NL; i++) begin
                match[r][i] = (rank[i] == IW'(r));
                if (match[r][i])
                    order[r] = IW'(i);
            end
        end
    end

    generate
        for (genvar r = 0; r < NL; r++) begin : g_chk
            AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                $countones(match[r]) == 1); // R5
        end
    endgenerate

endmodule

// File: rtl/comp_layer_prep.sv
module comp_layer_prep
    import comp_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    input  logic [PIX_W-1:0] pix,
    input  logic [CW-1:0]    alpha,
    input  logic [XW-1:0]    x0,
    input  logic [YW-1:0]    y0,
    input  logic [XW-1:0]    w,
    input  logic [YW-1:0]    h,
    input  logic [CW-1:0]    galpha,
    input  logic             premul,
    input  logic             key_en,
    input  logic [PIX_W-1:0] key,
    output term_t            term
);

    logic [XW:0] x_end;
    logic [YW:0] y_end;
    logic        in_x;
    logic        in_y;
    logic        keyed;
    rgb_t        px;
    rgb_t        scaled;

    assign x_end = {1'b0, x0} + {1'b0, w};
    assign y_end = {1'b0, y0} + {1'b0, h};
    assign in_x  = (x >= x0) && ({1'b0, x} < x_end);
    assign in_y  = (y >= y0) && ({1'b0, y} < y_end);
    assign keyed = key_en && (pix == key);
    assign px    = rgb_t'(pix);

    always_comb begin
        scaled.r = mul_norm(px.r, galpha);
        scaled.g = mul_norm(px.g, galpha);
        scaled.b = mul_norm(px.b, galpha);
    end

    always_comb begin
        term.hit    = in_x && in_y && !keyed;
        term.alpha  = mul_norm(alpha, galpha);
        term.premul = premul;
        term.src    = premul ? scaled : px;
    end

endmodule

// File: rtl/comp_blend_step.sv
module comp_blend_step
    import comp_pkg::*;
(
    input  rgb_t  dst,
    input  term_t term,
    output rgb_t  res
);

    always_comb res = fold_px(dst, term);

endmodule

// File: rtl/alpha_compositor.sv
module alpha_compositor
    import comp_pkg::*;
#(
    parameter int NL = 4,
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int ZW = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [XW-1:0]              in_x,
    input  logic [YW-1:0]              in_y,
    input  logic [NL-1:0][PIX_W-1:0]   in_pix,
    input  logic [NL-1:0][CW-1:0]      in_alpha,
    input  logic [NL-1:0][XW-1:0]      cfg_x0,
    input  logic [NL-1:0][YW-1:0]      cfg_y0,
    input  logic [NL-1:0][XW-1:0]      cfg_w,
    input  logic [NL-1:0][YW-1:0]      cfg_h,
    input  logic [NL-1:0][ZW-1:0]      cfg_z,
    input  logic [NL-1:0][CW-1:0]      cfg_galpha,
    input  logic [NL-1:0]              cfg_premul,
    input  logic [NL-1:0]              cfg_key_en,
    input  logic [NL-1:0][PIX_W-1:0]   cfg_key,
    input  logic [PIX_W-1:0]           cfg_bg,
    output logic                       out_valid,
    output logic [XW-1:0]              out_x,
    output logic [YW-1:0]              out_y,
    output logic [PIX_W-1:0]           out_pix
);

    localparam int IW = (NL > 1) ? $clog2(NL) : 1;

    logic [NL-1:0][IW-1:0] order;
    term_t                 raw   [NL];
    logic [NL-1:0]         raw_hit;

    // stage registers
    term_t       s1_t [NL];
    term_t       s2_t [NL];
    term_t       s3_t [NL];
    rgb_t        s1_d, s2_d, s3_d, s4_d;
    logic        s1_v, s2_v, s3_v, s4_v;
    logic        s1_any, s2_any, s3_any, s4_any;
    logic [XW-1:0] s1_x, s2_x, s3_x, s4_x;
    logic [YW-1:0] s1_y, s2_y, s3_y, s4_y;

    rgb_t        chain [NL-1];
    rgb_t        step_b_out;
    rgb_t        step_c_out;

    comp_zsort #(.NL(NL), .ZW(ZW), .IW(IW)) u_sort (
        .clk   (clk),
        .rst   (rst),
        .z     (cfg_z),
        .order (order)
    );

    generate
        for (genvar i = 0; i < NL; i++) begin : g_prep
            comp_layer_prep #(.XW(XW), .YW(YW)) u_prep (
                .x      (in_x),
                .y      (in_y),
                .pix    (in_pix[i]),
                .alpha  (in_alpha[i]),
                .x0     (cfg_x0[i]),
                .y0     (cfg_y0[i]),
                .w      (cfg_w[i]),
                .h      (cfg_h[i]),
                .galpha (cfg_galpha[i]),
                .premul (cfg_premul[i]),
                .key_en (cfg_key_en[i]),
                .key    (cfg_key[i]),
                .term   (raw[i])
            );
            assign raw_hit[i] = raw[i].hit;
        end
    endgenerate

    // stage 1: per-layer terms, placed in fold order
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v   <= 1'b0;
            s1_any <= 1'b0;
            s1_x   <= '0;
            s1_y   <= '0;
            s1_d   <= '0;
            for (int r = 0; r < NL; r++) s1_t[r] <= '0;
        end else begin
            s1_v   <= in_valid;
            s1_any <= |raw_hit;
            s1_x   <= in_x;
            s1_y   <= in_y;
            s1_d   <= rgb_t'(cfg_bg);
            for (int r = 0; r < NL; r++) s1_t[r] <= raw[order[r]];
        end
    end

    // stage 2: fold all but the top two ranks
    assign chain[0] = s1_d;
    generate
        for (genvar k = 0; k < NL - 2; k++) begin : g_chain
            comp_blend_step u_step (
                .dst  (chain[k]),
                .term (s1_t[k]),
                .res  (chain[k+1])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v   <= 1'b0;
            s2_any <= 1'b0;
            s2_x   <= '0;
            s2_y   <= '0;
            s2_d   <= '0;
            for (int r = 0; r < NL; r++) s2_t[r] <= '0;
        end else begin
            s2_v   <= s1_v;
            s2_any <= s1_any;
            s2_x   <= s1_x;
            s2_y   <= s1_y;
            s2_d   <= chain[NL-2];
            for (int r = 0; r < NL; r++) s2_t[r] <= s1_t[r];
        end
    end

    // stage 3: second highest rank
    comp_blend_step u_step_b (
        .dst  (s2_d),
        .term (s2_t[NL-2]),
        .res  (step_b_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_v   <= 1'b0;
            s3_any <= 1'b0;
            s3_x   <= '0;
            s3_y   <= '0;
            s3_d   <= '0;
            for (int r = 0; r < NL; r++) s3_t[r] <= '0;
        end else begin
            s3_v   <= s2_v;
            s3_any <= s2_any;
            s3_x   <= s2_x;
            s3_y   <= s2_y;
            s3_d   <= step_b_out;
            for (int r = 0; r < NL; r++) s3_t[r] <= s2_t[r];
        end
    end

    // stage 4: top rank
    comp_blend_step u_step_c (
        .dst  (s3_d),
        .term (s3_t[NL-1]),
        .res  (step_c_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s4_v   <= 1'b0;
            s4_any <= 1'b0;
            s4_x   <= '0;
            s4_y   <= '0;
            s4_d   <= '0;
        end else begin
            s4_v   <= s3_v;
            s4_any <= s3_any;
            s4_x   <= s3_x;
            s4_y   <= s3_y;
            s4_d   <= step_c_out;
        end
    end

    assign out_valid = s4_v;
    assign out_x     = s4_x;
    assign out_y     = s4_y;
    assign out_pix   = PIX_W'(s4_d);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##4 out_valid); // R1

    AST_COORD_CARRY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##4 ((out_x == $past(in_x, 4)) && (out_y == $past(in_y, 4)))); // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##4 !out_valid); // R1

    AST_BG_UNCOVERED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(|raw_hit)) |-> ##4 (out_pix == $past(cfg_bg, 4))); // R8

endmodule

// File: tb/sim_alpha_compositor.sv
`timescale 1ns/1ps
module sim_alpha_compositor;

    localparam int NL = 4;
    localparam int XW = 12;
    localparam int YW = 12;
    localparam int ZW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic [NL-1:0][23:0] in_pix = '0;
    logic [NL-1:0][7:0]  in_alpha = '0;
    logic [NL-1:0][XW-1:0] cfg_x0 = '0;
    logic [NL-1:0][YW-1:0] cfg_y0 = '0;
    logic [NL-1:0][XW-1:0] cfg_w = '0;
    logic [NL-1:0][YW-1:0] cfg_h = '0;
    logic [NL-1:0][ZW-1:0] cfg_z = '0;
    logic [NL-1:0][7:0]  cfg_galpha = '0;
    logic [NL-1:0]       cfg_premul = '0;
    logic [NL-1:0]       cfg_key_en = '0;
    logic [NL-1:0][23:0] cfg_key = '0;
    logic [23:0]         cfg_bg = '0;
    logic                out_valid;
    logic [XW-1:0]       out_x;
    logic [YW-1:0]       out_y;
    logic [23:0]         out_pix;

    int checks = 0;
    int bad = 0;
    string cur_tag = "R9";

    logic [47:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    alpha_compositor #(.NL(NL), .XW(XW), .YW(YW), .ZW(ZW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_pix(in_pix), .in_alpha(in_alpha), .cfg_x0(cfg_x0), .cfg_y0(cfg_y0),
        .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_z(cfg_z), .cfg_galpha(cfg_galpha),
        .cfg_premul(cfg_premul), .cfg_key_en(cfg_key_en), .cfg_key(cfg_key),
        .cfg_bg(cfg_bg), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_pix(out_pix)
    );

    function automatic int rnd255(input int p);
        return (p * 2 + 255) / 510;
    endfunction

    function automatic logic [23:0] model(input int x, input int y);
        int dst [3];
        int src [3];
        int a;
        for (int c = 0; c < 3; c++) dst[c] = int'(cfg_bg[16 - 8*c +: 8]);
        for (int zv = 0; zv < (1 << ZW); zv++) begin
            for (int i = 0; i < NL; i++) begin
                if (int'(cfg_z[i]) != zv) continue;
                if (x < int'(cfg_x0[i]) || x >= int'(cfg_x0[i]) + int'(cfg_w[i])) continue;
                if (y < int'(cfg_y0[i]) || y >= int'(cfg_y0[i]) + int'(cfg_h[i])) continue;
                if (cfg_key_en[i] && in_pix[i] == cfg_key[i]) continue;
                a = rnd255(int'(in_alpha[i]) * int'(cfg_galpha[i]));
                for (int c = 0; c < 3; c++) src[c] = int'(in_pix[i][16 - 8*c +: 8]);
                for (int c = 0; c < 3; c++) begin
                    if (cfg_premul[i]) begin
                        dst[c] = rnd255(src[c] * int'(cfg_galpha[i])) + rnd255(dst[c] * (255 - a));
                        if (dst[c] > 255) dst[c] = 255;
                    end else begin
                        dst[c] = rnd255(src[c] * a + dst[c] * (255 - a));
                    end
                end
            end
        end
        return {dst[0][7:0], dst[1][7:0], dst[2][7:0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // output checker: every valid output is matched against the expected queue
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1", 64'(out_valid), 64'(0));
            end else begin
                logic [47:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 64'({out_x, out_y, out_pix}), 64'(e));
            end
        end
    end

    task automatic clear_cfg();
        cfg_x0 = '0; cfg_y0 = '0; cfg_w = '0; cfg_h = '0; cfg_z = '0;
        cfg_galpha = {NL{8'd255}}; cfg_premul = '0; cfg_key_en = '0; cfg_key = '0;
        cfg_bg = 24'h102030;
        in_alpha = {NL{8'd255}};
    endtask

    task automatic full_cover(input int i);
        cfg_x0[i] = '0; cfg_y0[i] = '0; cfg_w[i] = 12'hFFF; cfg_h[i] = 12'hFFF;
    endtask

    // drive one position at a negative edge and queue its expected result
    task automatic send(input int x, input int y);
        in_valid = 1'b1;
        in_x = XW'(x);
        in_y = YW'(y);
        exp_q.push_back({XW'(x), YW'(y), model(x, y)});
        tag_q.push_back(cur_tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_cfg();
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", 64'(out_valid), 64'(0));
        check("R9", 64'(out_pix), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R9", 64'(out_valid), 64'(0));

        // R8: nothing drawn -> background
        cur_tag = "R8";
        in_pix = {24'h111111, 24'h222222, 24'h333333, 24'h444444};
        send(0, 0); send(77, 5); send(4095, 4095);
        cfg_x0[2] = 12'd100; cfg_w[2] = 12'd10; cfg_h[2] = 12'd10;
        send(50, 3);
        drain();

        // R2: rectangle edges, inclusive start and exclusive end
        cur_tag = "R2";
        clear_cfg();
        cfg_x0[0] = 12'd10; cfg_w[0] = 12'd5; cfg_y0[0] = 12'd20; cfg_h[0] = 12'd3;
        in_pix[0] = 24'hAABBCC;
        send(9, 20); send(10, 20); send(14, 20); send(15, 20);
        send(12, 19); send(12, 22); send(12, 23);
        drain();

        // R3: straight alpha with global opacity
        cur_tag = "R3";
        clear_cfg();
        full_cover(0);
        cfg_galpha[0] = 8'd200;
        in_alpha[0] = 8'd128;
        in_pix[0] = 24'hF04010;
        send(1, 1);
        in_pix[0] = 24'h00FF80;
        in_alpha[0] = 8'd1;
        send(2, 1);
        cfg_galpha[0] = 8'd255;
        in_alpha[0] = 8'd255;
        send(3, 1);
        in_alpha[0] = 8'd0;
        send(4, 1);
        drain();

        // R4: premultiplied alpha, including saturation
        cur_tag = "R4";
        clear_cfg();
        full_cover(1);
        cfg_premul[1] = 1'b1;
        cfg_galpha[1] = 8'd128;
        in_alpha[1] = 8'd100;
        in_pix[1] = 24'h804020;
        send(5, 5);
        cfg_bg = 24'hFFFFFF;
        in_pix[1] = 24'hFFFFFF;
        in_alpha[1] = 8'd0;
        cfg_galpha[1] = 8'd255;
        send(6, 5);
        drain();

        // R5: rank decides stacking
        cur_tag = "R5";
        clear_cfg();
        full_cover(0); full_cover(1);
        in_pix[0] = 24'hFF0000; in_pix[1] = 24'h00FF00;
        cfg_z[0] = 2'd3; cfg_z[1] = 2'd0;
        send(7, 7);
        drain();
        cfg_z[0] = 2'd0; cfg_z[1] = 2'd3;
        send(7, 8);
        drain();
        in_alpha[1] = 8'd90;
        send(7, 9);
        drain();

        // R6: equal ranks, higher index on top
        cur_tag = "R6";
        clear_cfg();
        full_cover(0); full_cover(1); full_cover(2);
        in_pix[0] = 24'h0000FF; in_pix[1] = 24'h00FF00; in_pix[2] = 24'hFF0000;
        cfg_z[0] = 2'd1; cfg_z[1] = 2'd1; cfg_z[2] = 2'd0;
        send(8, 8);
        drain();
        cfg_z[2] = 2'd1;
        send(8, 9);
        drain();

        // R7: transparency key
        cur_tag = "R7";
        clear_cfg();
        full_cover(3);
        cfg_key[3] = 24'h123456;
        cfg_key_en[3] = 1'b1;
        in_pix[3] = 24'h123456;
        send(9, 9);
        in_pix[3] = 24'h123457;
        send(10, 9);
        cfg_key_en[3] = 1'b0;
        in_pix[3] = 24'h123456;
        send(11, 9);
        drain();

        // R1: exact output timing of a single pulse
        cur_tag = "R1";
        send(33, 44);
        for (int k = 1; k <= 3; k++) begin
            check("R1", 64'(out_valid), 64'(0));
            @(negedge clk);
        end
        check("R1", 64'({out_valid, out_x, out_y}), 64'({1'b1, 12'd33, 12'd44}));
        drain();

        // random configurations mixing ranks, modes, keys and overlaps (R5)
        cur_tag = "R5";
        for (int cfgn = 0; cfgn < 12; cfgn++) begin
            cfg_bg = 24'($urandom);
            for (int i = 0; i < NL; i++) begin
                cfg_x0[i] = XW'($urandom_range(0, 40));
                cfg_y0[i] = YW'($urandom_range(0, 40));
                cfg_w[i] = XW'($urandom_range(0, 40));
                cfg_h[i] = YW'($urandom_range(0, 40));
                cfg_z[i] = ZW'($urandom);
                cfg_galpha[i] = 8'($urandom);
                cfg_premul[i] = 1'($urandom);
                cfg_key_en[i] = 1'($urandom);
                cfg_key[i] = 24'($urandom);
            end
            for (int p = 0; p < 150; p++) begin
                for (int i = 0; i < NL; i++) begin
                    in_pix[i] = ($urandom_range(0, 5) == 0) ? cfg_key[i] : 24'($urandom);
                    in_alpha[i] = ($urandom_range(0, 7) == 0) ? 8'd255 : 8'($urandom);
                end
                if ($urandom_range(0, 4) == 0) @(negedge clk);
                send($urandom_range(0, 80), $urandom_range(0, 80));
            end
            drain();
        end

        check("R1", 64'(exp_q.size()), 64'(0));
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule